// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block tracks control flow for one warp of threads that share a single instruction stream. It keeps a small stack of entries, each holding the next PC of a path, the PC at which that path rejoins its siblings, and the set of threads that follow it. The top entry decides what the warp does now: its PC goes to instruction fetch and its thread mask goes to issue.

Two kinds of events arrive from the pipeline. A sequential step reports the warp's next PC after an ordinary instruction. A branch reports a per-thread taken mask, both targets and the rejoin PC, which is worked out elsewhere. A branch on which every active thread agrees only moves the top PC. A branch that splits the active threads parks the current entry at the rejoin PC, then pushes the fall-through path and the taken path, with the taken path on top. Whenever the PC written to the top would equal that entry's rejoin PC, the entry is dropped and the path beneath it resumes. All of this takes effect at the next clock edge.

Two refinements keep the stack shallow. A path whose target already equals the rejoin PC is not pushed. A split whose rejoin PC equals the rejoin PC of the current top replaces the top instead of parking it. A split that would not fit sets a sticky error flag and leaves the stack untouched.

Top module: `warp_reconv_stack`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the stack holds exactly one entry: fetch_pc equals start_pc, active_mask is all ones, overflow_err is 0, and that bottom entry has no rejoin PC, so it is never removed.
- R2: fetch_pc and active_mask always show the top entry, and they change only at the clock edge that follows a step or branch event. With neither event present they stay unchanged.
- R3: A step (step_valid high) whose step_pc differs from the top entry's rejoin PC replaces the top PC with step_pc and keeps the mask.
- R4: When the PC about to be written to the top entry, from a step or a uniform branch, equals that entry's valid rejoin PC, the entry is removed, and the entry below it supplies fetch_pc and active_mask.
- R5: The effective taken set is br_mask AND active_mask. If it equals active_mask, the branch is uniform and goes to br_taken_pc. If it is zero, the branch is uniform and goes to br_fall_pc. A uniform branch pushes nothing and keeps the mask.
- R6: Any other branch splits. The top PC becomes br_reconv_pc. An entry with PC br_fall_pc and mask active_mask AND NOT br_mask is pushed. Then an entry with PC br_taken_pc and mask active_mask AND br_mask is pushed on top. Both new entries get br_reconv_pc as their rejoin PC.
- R7: During a split, a path whose target equals br_reconv_pc is not pushed.
- R8: During a split whose br_reconv_pc equals the valid rejoin PC of the current top, the top entry is replaced by the new entries instead of being kept beneath them.
- R9: A split that would need more than DEPTH entries sets overflow_err and leaves every entry and the depth unchanged. overflow_err stays set until reset.
- R10: When br_valid and step_valid are both high, the branch is applied and the step is ignored.
- R11: Bits of br_mask that belong to threads outside active_mask have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_pc | input | PC_W | Kernel entry PC, loaded into the bottom entry during reset |
| step_valid | input | 1 | A non-branch instruction completed for the warp |
| step_pc | input | PC_W | PC that follows that instruction |
| br_valid | input | 1 | A branch resolved for the warp |
| br_mask | input | WARP_W | Per-thread taken outcome of the branch |
| br_taken_pc | input | PC_W | Target of the taken path |
| br_fall_pc | input | PC_W | Target of the fall-through path |
| br_reconv_pc | input | PC_W | Rejoin PC (immediate post-dominator) of the branch |
| fetch_pc | output | PC_W | PC of the top entry, to fetch |
| active_mask | output | WARP_W | Thread mask of the top entry, to issue |
| overflow_err | output | 1 | Sticky flag: a split did not fit in the stack |

## Verification
The hardest states to reach are the deep ones. The stack is full, a nested split shares its rejoin PC with the enclosing split, or the warp runs inside a partial mask while the branch outcome covers only inactive threads. The bench reaches them with a small configuration of eight threads and four entries, which makes a two-level nest enough to reach the limit. The same nest then either fits through the top replacement or overflows, depending only on the inner rejoin PC. Every one of the 256 taken masks is also driven from the full warp, and the expected path order and masks are derived arithmetically.

// File: rtl/reconv_pkg.sv
package reconv_pkg;

    // Outcome of a branch once inactive threads are masked out
    typedef enum logic [1:0] {
        PATH_FALL  = 2'd0,
        PATH_TAKEN = 2'd1,
        PATH_SPLIT = 2'd2
    } path_kind_e;

    // Number of write ports on the entry file: top rewrite, lower push, upper push
    localparam int NUM_WR = 3;

endpackage

// File: rtl/warp_branch_split.sv
module warp_branch_split
    import reconv_pkg::*;
#(
    parameter int WARP_W = 32
) (
    input  logic [WARP_W-1:0] act_mask,
    input  logic [WARP_W-1:0] br_mask,
    output logic [WARP_W-1:0] eff_taken,
    output logic [WARP_W-1:0] eff_fall,
    output path_kind_e        kind
);

    always_comb begin
        eff_taken = act_mask & br_mask;
        eff_fall  = act_mask & ~br_mask;
        if (eff_fall == '0) begin
            kind = PATH_TAKEN;
        end else if (eff_taken == '0) begin
            kind = PATH_FALL;
        end else begin
            kind = PATH_SPLIT;
        end
    end

endmodule

// File: rtl/warp_stack_regs.sv
module warp_stack_regs
    import reconv_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PC_W   = 32,
    parameter int WARP_W = 32,
    parameter int IW     = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PC_W-1:0]               start_pc,
    input  logic [NUM_WR-1:0]             wr_en,
    input  logic [NUM_WR-1:0][IW-1:0]     wr_idx,
    input  logic [NUM_WR-1:0][PC_W-1:0]   wr_pc,
    input  logic [NUM_WR-1:0][PC_W-1:0]   wr_rpc,
    input  logic [NUM_WR-1:0]             wr_rv,
    input  logic [NUM_WR-1:0][WARP_W-1:0] wr_mask,
    input  logic [IW-1:0]                 rd_idx,
    output logic [PC_W-1:0]               rd_pc,
    output logic [PC_W-1:0]               rd_rpc,
    output logic                          rd_rv,
    output logic [WARP_W-1:0]             rd_mask
);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [PC_W-1:0]   rpc;
        logic              rv;
        logic [WARP_W-1:0] mask;
    } entry_t;

    entry_t ent_v [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        entry_t ent_d;
        entry_t ent_q;

        always_comb begin
            ent_d = ent_q;
            for (int p = 0; p < NUM_WR; p++) begin
                if (wr_en[p] && (wr_idx[p] == IW'(e))) begin
                    ent_d = '{pc: wr_pc[p], rpc: wr_rpc[p], rv: wr_rv[p], mask: wr_mask[p]};
                end
            end
            if (!rst_n) begin
                if (e == 0) begin
                    ent_d = '{pc: start_pc, rpc: '0, rv: 1'b0, mask: '1};
                end else begin
                    ent_d = '0;
                end
            end
        end

        always_ff @(posedge clk) begin
            ent_q <= ent_d;
        end

        assign ent_v[e] = ent_q;
    end

    always_comb begin
        rd_pc   = ent_v[rd_idx].pc;
        rd_rpc  = ent_v[rd_idx].rpc;
        rd_rv   = ent_v[rd_idx].rv;
        rd_mask = ent_v[rd_idx].mask;
    end

endmodule

// File: rtl/warp_reconv_stack.sv
module warp_reconv_stack
    import reconv_pkg::*;
#(
    parameter int WARP_W = 32,
    parameter int DEPTH  = 8,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   start_pc,
    input  logic              step_valid,
    input  logic [PC_W-1:0]   step_pc,
    input  logic              br_valid,
    input  logic [WARP_W-1:0] br_mask,
    input  logic [PC_W-1:0]   br_taken_pc,
    input  logic [PC_W-1:0]   br_fall_pc,
    input  logic [PC_W-1:0]   br_reconv_pc,
    output logic [PC_W-1:0]   fetch_pc,
    output logic [WARP_W-1:0] active_mask,
    output logic              overflow_err
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 3);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          err;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    logic [PC_W-1:0]   top_pc;
    logic [PC_W-1:0]   top_rpc;
    logic              top_rv;
    logic [WARP_W-1:0] top_mask;
    logic [IW-1:0]     top_idx;

    logic [WARP_W-1:0] eff_taken;
    logic [WARP_W-1:0] eff_fall;
    path_kind_e        kind;

    logic [NUM_WR-1:0]             wr_en;
    logic [NUM_WR-1:0][IW-1:0]     wr_idx;
    logic [NUM_WR-1:0][PC_W-1:0]   wr_pc;
    logic [NUM_WR-1:0][PC_W-1:0]   wr_rpc;
    logic [NUM_WR-1:0]             wr_rv;
    logic [NUM_WR-1:0][WARP_W-1:0] wr_mask;

    logic              upd;
    logic [PC_W-1:0]   new_pc;
    logic              keep_top;
    logic              need_fall;
    logic              need_taken;
    logic [CW-1:0]     base;
    logic [CW-1:0]     next_cnt;
    logic [CW-1:0]     depth_cnt;

    assign top_idx = IW'(ctl_q.cnt - CW'(1));

    warp_branch_split #(
        .WARP_W (WARP_W)
    ) split_i (
        .act_mask  (top_mask),
        .br_mask   (br_mask),
        .eff_taken (eff_taken),
        .eff_fall  (eff_fall),
        .kind      (kind)
    );

    warp_stack_regs #(
        .DEPTH  (DEPTH),
        .PC_W   (PC_W),
        .WARP_W (WARP_W),
        .IW     (IW)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_pc (start_pc),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_pc    (wr_pc),
        .wr_rpc   (wr_rpc),
        .wr_rv    (wr_rv),
        .wr_mask  (wr_mask),
        .rd_idx   (top_idx),
        .rd_pc    (top_pc),
        .rd_rpc   (top_rpc),
        .rd_rv    (top_rv),
        .rd_mask  (top_mask)
    );

    always_comb begin
        ctl_d      = ctl_q;
        wr_en      = '0;
        wr_idx     = '0;
        wr_pc      = '0;
        wr_rpc     = '0;
        wr_rv      = '0;
        wr_mask    = '0;
        upd        = 1'b0;
        new_pc     = top_pc;
        keep_top   = !(top_rv && (top_rpc == br_reconv_pc));
        need_fall  = (br_fall_pc != br_reconv_pc);
        need_taken = (br_taken_pc != br_reconv_pc);
        base       = keep_top ? ctl_q.cnt : (ctl_q.cnt - CW'(1));
        next_cnt   = base + CW'(need_fall) + CW'(need_taken);

        if (br_valid) begin
            unique case (kind)
                PATH_TAKEN: begin
                    upd    = 1'b1;
                    new_pc = br_taken_pc;
                end
                PATH_FALL: begin
                    upd    = 1'b1;
                    new_pc = br_fall_pc;
                end
                default: begin
                    if (next_cnt > CW'(DEPTH)) begin
                        ctl_d.err = 1'b1;
                    end else begin
                        ctl_d.cnt  = next_cnt;
                        // park current path at the rejoin point
                        wr_en[0]   = keep_top;
                        wr_idx[0]  = top_idx;
                        wr_pc[0]   = br_reconv_pc;
                        wr_rpc[0]  = top_rpc;
                        wr_rv[0]   = top_rv;
                        wr_mask[0] = top_mask;
                        // fall-through path below
                        wr_en[1]   = need_fall;
                        wr_idx[1]  = IW'(base);
                        wr_pc[1]   = br_fall_pc;
                        wr_rpc[1]  = br_reconv_pc;
                        wr_rv[1]   = 1'b1;
                        wr_mask[1] = eff_fall;
                        // taken path on top
                        wr_en[2]   = need_taken;
                        wr_idx[2]  = IW'(base + CW'(need_fall));
                        wr_pc[2]   = br_taken_pc;
                        wr_rpc[2]  = br_reconv_pc;
                        wr_rv[2]   = 1'b1;
                        wr_mask[2] = eff_taken;
                    end
                end
            endcase
        end else if (step_valid) begin
            upd    = 1'b1;
            new_pc = step_pc;
        end

        if (upd) begin
            if (top_rv && (new_pc == top_rpc)) begin
                ctl_d.cnt = ctl_q.cnt - CW'(1);
            end else begin
                wr_en[0]   = 1'b1;
                wr_idx[0]  = top_idx;
                wr_pc[0]   = new_pc;
                wr_rpc[0]  = top_rpc;
                wr_rv[0]   = top_rv;
                wr_mask[0] = top_mask;
            end
        end

        if (!rst_n) begin
            ctl_d = '{cnt: CW'(1), err: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign depth_cnt    = ctl_q.cnt;
    assign fetch_pc     = top_pc;
    assign active_mask  = top_mask;
    assign overflow_err = ctl_q.err;

endmodule

// File: rtl/warp_reconv_stack_chk.sv
module warp_reconv_stack_chk #(
    parameter int WARP_W = 32,
    parameter int DEPTH  = 8,
    parameter int PC_W   = 32,
    parameter int CW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_valid,
    input logic              br_valid,
    input logic [WARP_W-1:0] br_mask,
    input logic [PC_W-1:0]   br_taken_pc,
    input logic [PC_W-1:0]   br_reconv_pc,
    input logic [PC_W-1:0]   fetch_pc,
    input logic [WARP_W-1:0] active_mask,
    input logic              overflow_err,
    input logic [CW-1:0]     depth_cnt
);

    // R9: the depth never leaves the range 1..DEPTH
    assert_depth_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_cnt >= CW'(1)) && (depth_cnt <= CW'(DEPTH)));

    // R9: error flag is sticky
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    // R9: error only rises after a branch event
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_err) |-> $past(br_valid));

    // R2: no event, no change at the outputs
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && !step_valid) |=> ($stable(fetch_pc) && $stable(active_mask)));

    // R2: the warp never runs with an empty mask
    assert_mask_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);

    // R6: a split that pushes its taken path leaves that path's threads on top (or nothing changes on overflow)
    assert_split_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && ((br_mask & active_mask) != '0) && ((~br_mask & active_mask) != '0)
         && (br_taken_pc != br_reconv_pc))
        |=> ((active_mask == $past(br_mask & active_mask)) || (active_mask == $past(active_mask))));

endmodule

bind warp_reconv_stack warp_reconv_stack_chk #(
    .WARP_W (WARP_W),
    .DEPTH  (DEPTH),
    .PC_W   (PC_W),
    .CW     (CW)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_valid   (step_valid),
    .br_valid     (br_valid),
    .br_mask      (br_mask),
    .br_taken_pc  (br_taken_pc),
    .br_reconv_pc (br_reconv_pc),
    .fetch_pc     (fetch_pc),
    .active_mask  (active_mask),
    .overflow_err (overflow_err),
    .depth_cnt    (depth_cnt)
);

// File: tb/warp_reconv_stack_tb_top.sv
module warp_reconv_stack_tb_top;

    localparam int WARP_W = 8;
    localparam int DEPTH  = 4;
    localparam int PC_W   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   start_pc = 16'h0010;
    logic              step_valid = 1'b0;
    logic [PC_W-1:0]   step_pc = '0;
    logic              br_valid = 1'b0;
    logic [WARP_W-1:0] br_mask = '0;
    logic [PC_W-1:0]   br_taken_pc = '0;
    logic [PC_W-1:0]   br_fall_pc = '0;
    logic [PC_W-1:0]   br_reconv_pc = '0;
    logic [PC_W-1:0]   fetch_pc;
    logic [WARP_W-1:0] active_mask;
    logic              overflow_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    warp_reconv_stack #(
        .WARP_W (WARP_W),
        .DEPTH  (DEPTH),
        .PC_W   (PC_W)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_pc     (start_pc),
        .step_valid   (step_valid),
        .step_pc      (step_pc),
        .br_valid     (br_valid),
        .br_mask      (br_mask),
        .br_taken_pc  (br_taken_pc),
        .br_fall_pc   (br_fall_pc),
        .br_reconv_pc (br_reconv_pc),
        .fetch_pc     (fetch_pc),
        .active_mask  (active_mask),
        .overflow_err (overflow_err)
    );

    task automatic check(input string req, input logic [PC_W-1:0] exp_pc,
                         input logic [WARP_W-1:0] exp_mask, input logic exp_err);
        checks++;
        if (fetch_pc !== exp_pc || active_mask !== exp_mask || overflow_err !== exp_err) begin
            errors++;
            $display("FAIL %s actual pc=%h mask=%h err=%b expected pc=%h mask=%h err=%b",
                     req, fetch_pc, active_mask, overflow_err, exp_pc, exp_mask, exp_err);
        end
    endtask

    task automatic do_reset(input logic [PC_W-1:0] spc);
        @(negedge clk);
        rst_n    = 1'b0;
        start_pc = spc;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_step(input logic [PC_W-1:0] pc);
        @(negedge clk);
        step_valid = 1'b1;
        step_pc    = pc;
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    task automatic do_branch(input logic [WARP_W-1:0] m, input logic [PC_W-1:0] tpc,
                             input logic [PC_W-1:0] fpc, input logic [PC_W-1:0] rpc);
        @(negedge clk);
        br_valid     = 1'b1;
        br_mask      = m;
        br_taken_pc  = tpc;
        br_fall_pc   = fpc;
        br_reconv_pc = rpc;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2 actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(16'h0010);
        check("R1 reset", 16'h0010, 8'hFF, 1'b0);
        // R1/R2: idle cycles keep the top
        @(negedge clk);
        @(negedge clk);
        check("R2 idle hold", 16'h0010, 8'hFF, 1'b0);
        // R3 and R1: a step from the bottom never pops
        do_step(16'h0014);
        check("R3 step", 16'h0014, 8'hFF, 1'b0);

        // R5/R6/R4: every taken mask from a full warp
        for (int m = 0; m < 256; m++) begin
            logic [WARP_W-1:0] mm;
            mm = WARP_W'(m);
            do_reset(16'h0020);
            do_branch(mm, 16'h0100, 16'h0200, 16'h0300);
            if (mm == 8'hFF) begin
                check("R5 uniform taken", 16'h0100, 8'hFF, 1'b0);
            end else if (mm == 8'h00) begin
                check("R5 uniform fall", 16'h0200, 8'hFF, 1'b0);
            end else begin
                check("R6 split taken on top", 16'h0100, mm, 1'b0);
            end
            do_step(16'h0300);
            if (mm == 8'hFF || mm == 8'h00) begin
                check("R5 no push", 16'h0300, 8'hFF, 1'b0);
            end else begin
                check("R4 pop to fall path", 16'h0200, ~mm, 1'b0);
            end
            do_step(16'h0300);
            check("R4 rejoin full warp", 16'h0300, 8'hFF, 1'b0);
        end

        // R8: nested split sharing the rejoin PC fits by replacing the top
        do_reset(16'h0010);
        do_branch(8'h0F, 16'h0020, 16'h0040, 16'h0080);
        check("R6 outer split", 16'h0020, 8'h0F, 1'b0);
        do_branch(8'h03, 16'h0030, 16'h0050, 16'h0080);
        check("R8 merged split", 16'h0030, 8'h03, 1'b0);
        do_step(16'h0080);
        check("R8 inner fall", 16'h0050, 8'h0C, 1'b0);
        do_step(16'h0080);
        check("R8 outer fall", 16'h0040, 8'hF0, 1'b0);
        do_step(16'h0080);
        check("R8 rejoined", 16'h0080, 8'hFF, 1'b0);

        // R9: nested split with its own rejoin PC overflows four entries
        do_reset(16'h0010);
        do_branch(8'h0F, 16'h0020, 16'h0040, 16'h0080);
        do_branch(8'h03, 16'h0030, 16'h0050, 16'h0070);
        check("R9 overflow no change", 16'h0020, 8'h0F, 1'b1);
        do_step(16'h0080);
        check("R9 stack intact and sticky", 16'h0040, 8'hF0, 1'b1);
        do_step(16'h0080);
        check("R9 still sticky", 16'h0080, 8'hFF, 1'b1);
        do_reset(16'h0010);
        check("R9 reset clears", 16'h0010, 8'hFF, 1'b0);

        // R11: outcome bits of inactive threads are ignored
        do_branch(8'h0F, 16'h0020, 16'h0040, 16'h0080);
        do_branch(8'hF0, 16'h0060, 16'h0024, 16'h0099);
        check("R11 inactive bits ignored", 16'h0024, 8'h0F, 1'b0);
        do_branch(8'hFF, 16'h0060, 16'h0028, 16'h0099);
        check("R5 uniform in path", 16'h0060, 8'h0F, 1'b0);
        // R4: uniform branch onto the rejoin PC pops
        do_branch(8'hFF, 16'h0080, 16'h0064, 16'h0099);
        check("R4 uniform branch pops", 16'h0040, 8'hF0, 1'b0);
        // R3: step that does not match keeps the entry
        do_step(16'h0044);
        check("R3 step no pop", 16'h0044, 8'hF0, 1'b0);

        // R10: branch wins over a simultaneous step
        @(negedge clk);
        br_valid     = 1'b1;
        br_mask      = 8'hFF;
        br_taken_pc  = 16'h0090;
        br_fall_pc   = 16'h0048;
        br_reconv_pc = 16'h00A0;
        step_valid   = 1'b1;
        step_pc      = 16'h0080;
        @(negedge clk);
        br_valid   = 1'b0;
        step_valid = 1'b0;
        check("R10 branch priority", 16'h0090, 8'hF0, 1'b0);

        // R7: fall target equals rejoin PC, only taken path pushed
        do_reset(16'h0010);
        do_branch(8'h33, 16'h0020, 16'h0080, 16'h0080);
        check("R7 taken only", 16'h0020, 8'h33, 1'b0);
        do_step(16'h0080);
        check("R7 fall path skipped", 16'h0080, 8'hFF, 1'b0);
        // R7: taken target equals rejoin PC, only fall path pushed
        do_branch(8'h33, 16'h0090, 16'h0084, 16'h0090);
        check("R7 fall only", 16'h0084, 8'hCC, 1'b0);
        do_step(16'h0090);
        check("R7 taken path skipped", 16'h0090, 8'hFF, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule